// File: doc/BRIEF.md
# Parallel CAN CRC-15/17/21 Calculator Bank

This block keeps the three checksums used by classic CAN and CAN FD frames (15, 17 and 21 bits wide) for four separate serial bit streams at the same time. The four streams are the transmit and receive views of a frame, each taken once with stuff bits and once without. Every stream has its own enable, bit strobe and data bit. A run on a stream starts when its enable rises. The stream then takes in one data bit on each cycle that its strobe is high. The result stays frozen until that stream's enable rises again.

A two-level combinational selector drives the output ports from one of the four streams. The first level picks the with-stuff or without-stuff copy inside each group. The second level picks the receive or transmit group. A configuration input chooses the ISO or non-ISO FD flavour, which changes only the start value of the two longer registers. Each register update is a single XOR stage on top of a shift, so the path from the data bit to the flops stays short.

Top module: `crc_multi_bank`

## Requirements
- R1: The bank holds four independent calculators, indexed 0..3. Index bit 1 set means receive, and index bit 0 set means with stuff bits. Activity on one calculator's enable, strobe or data leaves the other three unchanged.
- R2: On the clock edge where a calculator's enable is sampled high after being low, all three of its registers load start values. CRC-15 loads 0. CRC-17 and CRC-21 load 0 when `fd_iso_i`=0, and load only their top bit set (0x10000 and 0x100000) when `fd_iso_i`=1.
- R3: A strobe on the start cycle is not absorbed. On later cycles with enable high, a high strobe absorbs that calculator's data bit into all three registers at once.
- R4: While enable is high, a cycle without a strobe leaves all three registers unchanged.
- R5: While enable is low, the registers hold their last value whatever the strobe and data do, until the next rising enable.
- R6: Each absorbed bit computes fb = bit XOR reg[MSB], then shifts the register left by one and XORs in the polynomial when fb=1. The polynomials, without the top term, are 0x4599 (15-bit), 0x1685B (17-bit) and 0x102899 (21-bit).
- R7: The outputs show calculator index {use_rx_i, use_wbs_i}, combinationally, with no clock delay.
- R8: While reset is asserted and after it is released, all twelve registers read 0.
- R9: A bit whose strobe is sampled on a clock edge shows at the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fd_iso_i | input | 1 | 1: ISO FD start values, 0: non-ISO |
| calc_en_i | input | 4 | Per-calculator run enable |
| bit_trig_i | input | 4 | Per-calculator bit strobe |
| bit_val_i | input | 4 | Per-calculator serial data bit |
| use_rx_i | input | 1 | Output selector: 1 receive group, 0 transmit group |
| use_wbs_i | input | 1 | Output selector: 1 with-stuff copy, 0 without |
| crc15_o | output | 15 | Selected CRC-15 |
| crc17_o | output | 17 | Selected CRC-17 |
| crc21_o | output | 21 | Selected CRC-21 |

## Verification
The assertions assume that `fd_iso_i` is steady on the cycle an enable rises. They also assume that the strobe and data inputs are driven to known values from reset onward, because the hold checks compare the registers across cycles based on the previous strobe and enable. The stimulus changes all inputs only at the falling clock edge and keeps every strobe low during reset. It changes `fd_iso_i` only while the enable of the addressed calculator is low. It drives one calculator at a time, and the other calculators are then checked to confirm their results were not disturbed.

// File: rtl/crc_multi_pkg.sv
package crc_multi_pkg;

    localparam int unsigned W15 = 15;
    localparam int unsigned W17 = 17;
    localparam int unsigned W21 = 21;

    localparam logic [W15-1:0] POLY15 = 15'h4599;
    localparam logic [W17-1:0] POLY17 = 17'h1685B;
    localparam logic [W21-1:0] POLY21 = 21'h102899;

    localparam int unsigned N_INST = 4;
    localparam int unsigned N_GRP  = N_INST / 2;

    typedef struct packed {
        logic [W21-1:0] c21;
        logic [W17-1:0] c17;
        logic [W15-1:0] c15;
    } crc_set_t;

endpackage

// File: rtl/crc_lane.sv
module crc_lane #(
    parameter int unsigned     W       = 15,
    parameter logic [W-1:0]    POLY    = '0,
    parameter bit              ISO_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         step_i,
    input  logic         bit_i,
    input  logic         fd_iso_i,
    output logic [W-1:0] crc_o
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] crc;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = bit_i ^ st_q.crc[W-1];
        if (start_i) begin
            st_d.crc = (ISO_TOP && fd_iso_i) ? TOP_BIT : '0;
        end else if (step_i) begin
            st_d.crc = {st_q.crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o = st_q.crc;

    AST_LANE_START_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i) |-> crc_o == ((ISO_TOP && $past(fd_iso_i)) ? TOP_BIT : '0)); // R2

    AST_LANE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && !$past(step_i)) |-> $stable(crc_o)); // R4

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_multi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     trig_i,
    input  logic     bit_i,
    input  logic     fd_iso_i,
    output crc_set_t crc_o
);

    typedef struct packed {
        logic en;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    rise;
    logic    step;

    always_comb begin
        st_d    = st_q;
        st_d.en = en_i;
        rise    = en_i & ~st_q.en;
        step    = en_i & trig_i & ~rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    crc_lane #(.W(W15), .POLY(POLY15), .ISO_TOP(1'b0)) u_l15 (
        .clk(clk), .rst_n(rst_n), .start_i(rise), .step_i(step),
        .bit_i(bit_i), .fd_iso_i(fd_iso_i), .crc_o(crc_o.c15));

    crc_lane #(.W(W17), .POLY(POLY17), .ISO_TOP(1'b1)) u_l17 (
        .clk(clk), .rst_n(rst_n), .start_i(rise), .step_i(step),
        .bit_i(bit_i), .fd_iso_i(fd_iso_i), .crc_o(crc_o.c17));

    crc_lane #(.W(W21), .POLY(POLY21), .ISO_TOP(1'b1)) u_l21 (
        .clk(clk), .rst_n(rst_n), .start_i(rise), .step_i(step),
        .bit_i(bit_i), .fd_iso_i(fd_iso_i), .crc_o(crc_o.c21));

    AST_ENG_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> $stable(crc_o)); // R5

    AST_ENG_START_CRC15_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !$past(st_q.en)) |-> crc_o.c15 == '0); // R2

endmodule

// File: rtl/crc_sel_mux.sv
module crc_sel_mux
    import crc_multi_pkg::*;
(
    input  crc_set_t sets_i [N_INST],
    input  logic     use_rx_i,
    input  logic     use_wbs_i,
    output crc_set_t set_o
);

    crc_set_t grp [N_GRP];

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_lvl1
            assign grp[g] = use_wbs_i ? sets_i[2*g+1] : sets_i[2*g];
        end
    endgenerate

    assign set_o = use_rx_i ? grp[1] : grp[0];

endmodule

// File: rtl/crc_multi_bank.sv
module crc_multi_bank
    import crc_multi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fd_iso_i,
    input  logic [N_INST-1:0]   calc_en_i,
    input  logic [N_INST-1:0]   bit_trig_i,
    input  logic [N_INST-1:0]   bit_val_i,
    input  logic                use_rx_i,
    input  logic                use_wbs_i,
    output logic [W15-1:0]      crc15_o,
    output logic [W17-1:0]      crc17_o,
    output logic [W21-1:0]      crc21_o
);

    crc_set_t sets [N_INST];
    crc_set_t sel;

    generate
        for (genvar i = 0; i < N_INST; i++) begin : g_inst
            crc_engine u_eng (
                .clk      (clk),
                .rst_n    (rst_n),
                .en_i     (calc_en_i[i]),
                .trig_i   (bit_trig_i[i]),
                .bit_i    (bit_val_i[i]),
                .fd_iso_i (fd_iso_i),
                .crc_o    (sets[i])
            );
        end
    endgenerate

    crc_sel_mux u_mux (
        .sets_i    (sets),
        .use_rx_i  (use_rx_i),
        .use_wbs_i (use_wbs_i),
        .set_o     (sel)
    );

    assign crc15_o = sel.c15;
    assign crc17_o = sel.c17;
    assign crc21_o = sel.c21;

    AST_TOP_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_trig_i) == '0 && $past(calc_en_i) == calc_en_i && $stable(use_rx_i)
         && $stable(use_wbs_i) && $past(calc_en_i) == $past(calc_en_i, 2))
        |-> ($stable(crc15_o) && $stable(crc17_o) && $stable(crc21_o))); // R4

endmodule

// File: tb/crc_multi_bank_tb_top.sv
`timescale 1ns/1ps
module crc_multi_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fd_iso = 1'b0;
    logic [3:0]  en = '0;
    logic [3:0]  trig = '0;
    logic [3:0]  val = '0;
    logic        use_rx = 1'b0;
    logic        use_wbs = 1'b0;
    logic [14:0] c15;
    logic [16:0] c17;
    logic [20:0] c21;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] e15 [4];
    logic [31:0] e17 [4];
    logic [31:0] e21 [4];

    always #2.5 clk = ~clk;

    crc_multi_bank dut_i (
        .clk(clk), .rst_n(rst_n), .fd_iso_i(fd_iso), .calc_en_i(en),
        .bit_trig_i(trig), .bit_val_i(val), .use_rx_i(use_rx), .use_wbs_i(use_wbs),
        .crc15_o(c15), .crc17_o(c17), .crc21_o(c21));

    // {inst[1:0], iso, nbits[5:0], pattern[31:0]}
    localparam logic [40:0] VECS [8] = '{
        {2'd0, 1'b0, 6'd8,  32'h000000A5},
        {2'd1, 1'b1, 6'd16, 32'h0000BEEF},
        {2'd2, 1'b0, 6'd32, 32'hDEADBEEF},
        {2'd3, 1'b1, 6'd11, 32'h000005F3},
        {2'd0, 1'b1, 6'd1,  32'h00000001},
        {2'd1, 1'b0, 6'd20, 32'h000F0F0F},
        {2'd2, 1'b1, 6'd0,  32'h00000000},
        {2'd3, 1'b0, 6'd32, 32'hFFFFFFFF}
    };

    function automatic logic [31:0] ref_crc(int w, logic [31:0] poly, logic [31:0] init,
                                            logic [31:0] pat, int n);
        logic [31:0] r;
        logic [31:0] mask;
        logic        fb;
        r    = init;
        mask = (32'd1 << w) - 32'd1;
        for (int i = 0; i < n; i++) begin
            fb = pat[i] ^ r[w-1];
            r  = ((r << 1) & mask) ^ (fb ? poly : 32'd0);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sel_inst(int inst);
        use_rx  = inst[1];
        use_wbs = inst[0];
        #1;
    endtask

    task automatic chk_inst(string req, int inst);
        sel_inst(inst);
        chk(req, {17'd0, c15}, e15[inst]);
        chk(req, {15'd0, c17}, e17[inst]);
        chk(req, {11'd0, c21}, e21[inst]);
    endtask

    task automatic run_frame(int inst, bit iso, int n, logic [31:0] pat);
        @(negedge clk);
        fd_iso    = iso;
        en[inst]  = 1'b1;
        trig[inst] = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % 3 == 2) begin
                trig[inst] = 1'b0;   // idle gap, R4
                @(negedge clk);
            end
            trig[inst] = 1'b1;
            val[inst]  = pat[i];
        end
        @(negedge clk);
        trig[inst] = 1'b0;
        en[inst]   = 1'b0;
        e15[inst] = ref_crc(15, 32'h4599, 32'd0, pat, n);
        e17[inst] = ref_crc(17, 32'h1685B, iso ? 32'h10000 : 32'd0, pat, n);
        e21[inst] = ref_crc(21, 32'h102899, iso ? 32'h100000 : 32'd0, pat, n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            e15[k] = '0; e17[k] = '0; e21[k] = '0;
        end
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) chk_inst("R8 reset held", k);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) chk_inst("R8 after reset", k);

        // table walk: R6 update rule, R1 instance index
        for (int v = 0; v < 8; v++) begin
            run_frame(int'(VECS[v][40:39]), VECS[v][38], int'(VECS[v][37:32]), VECS[v][31:0]);
            @(negedge clk);
            chk_inst("R6 frame result", int'(VECS[v][40:39]));
        end
        // R1 / R7: every instance kept its own result
        @(negedge clk);
        for (int k = 0; k < 4; k++) chk_inst("R1 R7 independent", k);

        // R3: strobe on start cycle is ignored; R2 ISO start values
        @(negedge clk);
        fd_iso = 1'b1; en[1] = 1'b1; trig[1] = 1'b1; val[1] = 1'b1;
        sel_inst(1);
        @(negedge clk);
        trig[1] = 1'b0;
        #1;
        chk("R2 iso crc15", {17'd0, c15}, 32'h0);
        chk("R2 iso crc17", {15'd0, c17}, 32'h10000);
        chk("R3 start strobe ignored", {11'd0, c21}, 32'h100000);

        // R5: disabled calculator ignores strobes
        @(negedge clk);
        en[1] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            trig[1] = 1'b1; val[1] = i[0];
        end
        @(negedge clk);
        trig[1] = 1'b0;
        #1;
        chk("R5 hold crc17", {15'd0, c17}, 32'h10000);
        chk("R5 hold crc21", {11'd0, c21}, 32'h100000);

        // R2 non-ISO restart clears the top bits
        fd_iso = 1'b0; en[1] = 1'b1;
        @(negedge clk);
        #1;
        chk("R2 noniso crc17", {15'd0, c17}, 32'h0);
        chk("R2 noniso crc21", {11'd0, c21}, 32'h0);
        en[1] = 1'b0;

        // R9 latency and single-bit values (R6)
        @(negedge clk);
        en[2] = 1'b1;
        sel_inst(2);
        @(negedge clk);
        trig[2] = 1'b1; val[2] = 1'b1;
        #1;
        chk("R9 not before edge", {17'd0, c15}, 32'h0);
        @(negedge clk);
        trig[2] = 1'b0;
        #1;
        chk("R9 crc15 after edge", {17'd0, c15}, 32'h4599);
        chk("R6 crc17 one bit", {15'd0, c17}, 32'h1685B);
        chk("R6 crc21 one bit", {11'd0, c21}, 32'h102899);
        // R4: idle cycles while enabled
        repeat (3) @(negedge clk);
        #1;
        chk("R4 idle hold", {17'd0, c15}, 32'h4599);
        en[2] = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule